// File: doc/BRIEF.md
# Multichannel Successive-Approximation Angle Sequencer

This block runs a time-shared angle digitizer that serves several sensor channels. A carrier-peak pulse makes it strobe every channel's sample-hold in the same clock cycle. It then works through a programmable scan list. For each scheduled entry it routes the analog multiplexer to that channel, waits a programmable settle time, and then runs a binary-angle successive-approximation search. The search drives a trial angle word to the external sine/cosine multipliers and reads back one comparator bit that says whether the error sine is positive.

Each scan-list slot names a channel and a pass divisor. A slot can therefore be visited on every pass, on every d-th pass, or never. A channel may appear in several slots, and the list order sets the conversion order. Finished words go into a per-channel result register and are announced by a one-cycle valid pulse that carries the channel index. If a carrier peak arrives while a pass is still running, the rest of that pass is dropped, an overrun pulse is raised, and a fresh pass starts from the new samples.

Top module: `angle_scan_seq`

## Requirements
- R1: While reset is held, `busy_o`, `sh_strobe_o`, `overrun_o` and `res_valid_o` are 0, and `trial_o`, `mux_sel_o` and every word of `results_o` are zero.
- R2: Every cycle in which `peak_i` is high produces exactly one cycle of `sh_strobe_o` in the following cycle, and `busy_o` is high in that cycle. With no peak, no strobe occurs.
- R3: A conversion makes NBITS decisions, starting at the MSB. The first trial word has only its MSB set, which is 180 degrees. Each decision sets the current bit to 1, and the bit stays 1 only if `cmp_i` is high. The result is therefore the largest word w for which every trial that kept a bit had `cmp_i` high. When the comparator is high exactly when the input angle is strictly above the trial, w equals the largest code strictly below the input angle, or 0 for an input of 0.
- R4: The second trial word is the first decision's bit followed by a 1 in the next bit. After a high comparator it is 1100...0 (270 degrees); after a low one it is 0100...0 (90 degrees).
- R5: Slots are visited in ascending slot index, and a slot at or above `list_len_i` is never visited. Slot s uses the channel index held in bits [s*CH_W +: CH_W] of `list_chan_i`. `mux_sel_o` only changes while `trial_o` is zero.
- R6: The divisor of slot s is held in bits [s*DIV_W +: DIV_W] of `list_div_i`. With an unchanged divisor d, the slot is visited on pass p (peaks counted from 0 after reset) exactly when d is not 0 and p mod d = 0. A divisor of 0 means the slot is never visited.
- R7: After `mux_sel_o` changes, the first trial word (MSB only) appears exactly `settle_i`+1 clock cycles later. Until then `trial_o` is zero.
- R8: Each finished conversion raises `res_valid_o` for one cycle, with `res_chan_o` and `res_word_o` set. In that same cycle, word `res_chan_o` of `results_o` equals `res_word_o`.
- R9: A peak that arrives while `busy_o` is high raises `overrun_o` for one cycle in the next cycle. The conversion in flight and the remaining slots of that pass produce no result, and a new pass starts.
- R10: When a pass has no visitable slot left, `busy_o` falls. While `busy_o` is low, `trial_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| peak_i | input | 1 | Carrier-peak pulse that starts a pass |
| list_len_i | input | LEN_W | Number of active scan-list slots |
| list_chan_i | input | NSLOT*CH_W | Channel index of each slot |
| list_div_i | input | NSLOT*DIV_W | Pass divisor of each slot (0 = never) |
| settle_i | input | SET_W | Settle clocks after a multiplexer switch |
| cmp_i | input | 1 | Comparator: error sine positive |
| sh_strobe_o | output | 1 | Hold strobe to all sample-holds |
| mux_sel_o | output | CH_W | Multiplexer channel select |
| trial_o | output | NBITS | Trial angle word to the multipliers |
| busy_o | output | 1 | Pass in progress |
| overrun_o | output | 1 | Peak arrived during a pass |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_chan_o | output | CH_W | Channel of the finished result |
| res_word_o | output | NBITS | Finished angle word |
| results_o | output | NCH*NBITS | Per-channel result registers |

## Verification
The bench models the comparator with input angles that have four bits more resolution than the word. It feeds angles that sit exactly on a code boundary (180 degrees), one step above it, zero, and full scale. A search that kept a bit on equality, or that ran one decision too few, would be off by one code at those points. It runs enough passes to reach the tenth pass of a divide-by-ten slot, with a zero-divisor slot and a slot beyond the list length present. A wrong pass counter or a wrong length compare would show up as a missing or extra scoreboard item. It also measures the settle delay, runs empty and single-slot passes, and fires a peak in the middle of a settle. A design that kept converting after an overrun would emit results that do not match the scoreboard.

// File: rtl/scan_seq_pkg.sv
// Shared types of the angle scan sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package scan_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PICK,
        ST_SETTLE,
        ST_SEARCH
    } seq_state_t;
endpackage

// File: rtl/scan_pass_sched.sv
// Per-slot pass counters: decides which scan-list slots run on the pass
// that the current peak starts.
// Assumes: pass_i is a one-cycle pulse per carrier peak; a divisor of 0
// disables its slot.
module scan_pass_sched #(
    parameter int NSLOT = 6,
    parameter int DIV_W = 4,
    parameter int LEN_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pass_i,
    input  logic [LEN_W-1:0]       len_i,
    input  logic [NSLOT*DIV_W-1:0] div_i,
    output logic [NSLOT-1:0]       visit_o
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [DIV_W-1:0] cnt_q;
        logic [DIV_W-1:0] div;
        assign div = div_i[s*DIV_W +: DIV_W];
        assign visit_o[s] = (div != '0) && (cnt_q == '0) && (LEN_W'(s) < len_i);

        // Advance this slot's pass count, wrapping at its divisor.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (pass_i) begin
                if (div == '0 || cnt_q >= div - 1'b1) cnt_q <= '0;
                else                                  cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scan_first_pick.sv
// Finds the lowest set bit of a pending-slot mask.
// Assumes: N >= 2.
module scan_first_pick #(
    parameter int N   = 6,
    parameter int IDW = 3
) (
    input  logic [N-1:0]   vec_i,
    output logic           found_o,
    output logic [IDW-1:0] idx_o
);
    // Scan downward so the lowest set bit wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/scan_sar_engine.sv
// Binary-angle successive-approximation engine: one decision per clock,
// from the MSB down.
// Assumes: cmp_i responds combinationally to trial_o; clear_i wins over
// start_i; NBITS >= 2.
module scan_sar_engine #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic [NBITS-1:0] trial_o,
    output logic             final_o,
    output logic [NBITS-1:0] word_o
);
    localparam int PTR_W = $clog2(NBITS);

    logic [NBITS-1:0] trial_q;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_dn;
    logic             act_q;

    assign ptr_dn  = ptr_q - PTR_W'(1);
    assign trial_o = trial_q;
    assign final_o = act_q && (ptr_q == '0);
    assign word_o  = {trial_q[NBITS-1:1], cmp_i};

    // Load, step or clear the trial word and its bit pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            trial_q <= '0;
            ptr_q   <= '0;
            act_q   <= 1'b0;
        end else if (start_i) begin
            trial_q <= {1'b1, {(NBITS-1){1'b0}}};
            ptr_q   <= PTR_W'(NBITS - 1);
            act_q   <= 1'b1;
        end else if (act_q) begin
            trial_q[ptr_q] <= cmp_i;
            if (ptr_q != '0) begin
                trial_q[ptr_dn] <= 1'b1;
                ptr_q           <= ptr_dn;
            end else begin
                act_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/angle_scan_seq.sv
// Multichannel sequencer: strobes all sample-holds at the carrier peak,
// then converts the scheduled slots one by one with a settle wait and a
// successive-approximation search.
// Assumes: cmp_i is valid in the same cycle as trial_o; a peak always
// starts a new pass and abandons any pass still running.
module angle_scan_seq #(
    parameter int NCH   = 4,
    parameter int NBITS = 8,
    parameter int NSLOT = 6,
    parameter int DIV_W = 4,
    parameter int SET_W = 4,
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int LEN_W  = $clog2(NSLOT + 1),
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   peak_i,
    input  logic [LEN_W-1:0]       list_len_i,
    input  logic [NSLOT*CH_W-1:0]  list_chan_i,
    input  logic [NSLOT*DIV_W-1:0] list_div_i,
    input  logic [SET_W-1:0]       settle_i,
    input  logic                   cmp_i,
    output logic                   sh_strobe_o,
    output logic [CH_W-1:0]        mux_sel_o,
    output logic [NBITS-1:0]       trial_o,
    output logic                   busy_o,
    output logic                   overrun_o,
    output logic                   res_valid_o,
    output logic [CH_W-1:0]        res_chan_o,
    output logic [NBITS-1:0]       res_word_o,
    output logic [NCH*NBITS-1:0]   results_o
);
    import scan_seq_pkg::*;

    seq_state_t        state_q;
    logic [NSLOT-1:0]  pend_q;
    logic [SET_W-1:0]  wait_q;
    logic [CH_W-1:0]   sel_q;
    logic              strobe_q;
    logic              ovr_q;
    logic              vld_q;
    logic [CH_W-1:0]   chan_q;
    logic [NBITS-1:0]  word_q;
    logic [NSLOT-1:0]  visit_now;
    logic              pick_found;
    logic [SLOT_W-1:0] pick_idx;
    logic              sar_clear;
    logic              sar_start;
    logic              sar_final;
    logic [NBITS-1:0]  sar_trial;
    logic [NBITS-1:0]  sar_word;
    logic              store_en;

    scan_pass_sched #(.NSLOT(NSLOT), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .pass_i  (peak_i),
        .len_i   (list_len_i),
        .div_i   (list_div_i),
        .visit_o (visit_now)
    );

    scan_first_pick #(.N(NSLOT), .IDW(SLOT_W)) u_pick (
        .vec_i   (pend_q),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    scan_sar_engine #(.NBITS(NBITS)) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (sar_clear),
        .start_i (sar_start),
        .cmp_i   (cmp_i),
        .trial_o (sar_trial),
        .final_o (sar_final),
        .word_o  (sar_word)
    );

    // Engine control and result write enable, derived from the state.
    always_comb begin
        sar_clear = peak_i || (state_q == ST_PICK);
        sar_start = (state_q == ST_SETTLE) && (wait_q == '0);
        store_en  = !peak_i && (state_q == ST_SEARCH) && sar_final;
    end

    // Pass sequencing: start or restart, pick the next slot, settle, search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pend_q   <= '0;
            wait_q   <= '0;
            sel_q    <= '0;
            strobe_q <= 1'b0;
            ovr_q    <= 1'b0;
            vld_q    <= 1'b0;
            chan_q   <= '0;
            word_q   <= '0;
        end else begin
            strobe_q <= peak_i;
            ovr_q    <= peak_i && (state_q != ST_IDLE);
            vld_q    <= 1'b0;
            if (peak_i) begin
                pend_q  <= visit_now;
                state_q <= ST_PICK;
            end else begin
                case (state_q)
                    ST_IDLE: ;
                    ST_PICK: begin
                        if (pick_found) begin
                            sel_q            <= list_chan_i[pick_idx*CH_W +: CH_W];
                            pend_q[pick_idx] <= 1'b0;
                            wait_q           <= settle_i;
                            state_q          <= ST_SETTLE;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_SETTLE: begin
                        if (wait_q == '0) state_q <= ST_SEARCH;
                        else              wait_q  <= wait_q - 1'b1;
                    end
                    ST_SEARCH: begin
                        if (sar_final) begin
                            vld_q   <= 1'b1;
                            chan_q  <= sel_q;
                            word_q  <= sar_word;
                            state_q <= ST_PICK;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_res
        logic [NBITS-1:0] res_q;
        assign results_o[c*NBITS +: NBITS] = res_q;

        // Hold the last finished word of channel c.
        always_ff @(posedge clk) begin
            if (!rst_n)                              res_q <= '0;
            else if (store_en && sel_q == CH_W'(c))  res_q <= sar_word;
        end
    end

    assign sh_strobe_o = strobe_q;
    assign mux_sel_o   = sel_q;
    assign trial_o     = sar_trial;
    assign busy_o      = (state_q != ST_IDLE);
    assign overrun_o   = ovr_q;
    assign res_valid_o = vld_q;
    assign res_chan_o  = chan_q;
    assign res_word_o  = word_q;
endmodule

// File: rtl/angle_scan_seq_chk.sv
// Temporal checks on the ports of angle_scan_seq, attached by bind.
// Assumes: synchronous active-low reset; NBITS >= 2.
module angle_scan_seq_chk #(
    parameter int NCH   = 4,
    parameter int NBITS = 8,
    parameter int CH_W  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 peak_i,
    input logic                 cmp_i,
    input logic                 sh_strobe_o,
    input logic [CH_W-1:0]      mux_sel_o,
    input logic [NBITS-1:0]     trial_o,
    input logic                 busy_o,
    input logic                 overrun_o,
    input logic                 res_valid_o,
    input logic [CH_W-1:0]      res_chan_o,
    input logic [NBITS-1:0]     res_word_o,
    input logic [NCH*NBITS-1:0] results_o
);
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

    assert_strobe_follows_peak_R2: assert property (@(posedge clk) disable iff (!rst_n)
        peak_i |=> (sh_strobe_o && busy_o));
    assert_no_strobe_without_peak_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_i |=> !sh_strobe_o);
    assert_second_trial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_o == MSB_ONLY && !peak_i) |=>
        (trial_o[NBITS-1] == $past(cmp_i) && trial_o[NBITS-2]));
    assert_mux_moves_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_sel_o) |-> (trial_o == '0));
    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);
    assert_result_stored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && int'(res_chan_o) < NCH) |->
        (results_o[res_chan_o*NBITS +: NBITS] == res_word_o));
    assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (peak_i && busy_o) |=> overrun_o);
    assert_overrun_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> !res_valid_o);
    assert_idle_trial_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (trial_o == '0));
endmodule

bind angle_scan_seq angle_scan_seq_chk #(.NCH(NCH), .NBITS(NBITS), .CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .peak_i      (peak_i),
    .cmp_i       (cmp_i),
    .sh_strobe_o (sh_strobe_o),
    .mux_sel_o   (mux_sel_o),
    .trial_o     (trial_o),
    .busy_o      (busy_o),
    .overrun_o   (overrun_o),
    .res_valid_o (res_valid_o),
    .res_chan_o  (res_chan_o),
    .res_word_o  (res_word_o),
    .results_o   (results_o)
);

// File: tb/tb_angle_scan_seq.sv
// Scoreboard bench: the driver pushes the expected results of each pass,
// and a monitor pops and compares them as results appear.
module tb_angle_scan_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4, NBITS = 8, NSLOT = 6, DIV_W = 4, SET_W = 4;
    localparam int CH_W = 2, LEN_W = 3, FB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic peak = 1'b0;
    logic cmp;
    logic [LEN_W-1:0]       len = '0;
    logic [NSLOT*CH_W-1:0]  lchan = '0;
    logic [NSLOT*DIV_W-1:0] ldiv = '0;
    logic [SET_W-1:0]       settle = '0;
    logic                   strobe, busy, ovr, valid;
    logic [CH_W-1:0]        sel, rchan;
    logic [NBITS-1:0]       trial, rword;
    logic [NCH*NBITS-1:0]   results;

    logic [NBITS+FB-1:0] ang [NCH];
    int sch  [NSLOT] = '{2, 0, 3, 1, 2, 1};
    int sdiv [NSLOT] = '{1, 10, 0, 2, 1, 1};
    int checks = 0, fails = 0, pass_no = 0, cyc = 0;
    logic [CH_W+NBITS-1:0] exp_q [$];
    logic [CH_W+NBITS-1:0] mon_item;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Comparator model: high when the fine input angle is above the trial.
    assign cmp = ang[sel] > {trial, {FB{1'b0}}};

    angle_scan_seq #(.NCH(NCH), .NBITS(NBITS), .NSLOT(NSLOT), .DIV_W(DIV_W), .SET_W(SET_W)) dut (
        .clk(clk), .rst_n(rst_n), .peak_i(peak), .list_len_i(len), .list_chan_i(lchan),
        .list_div_i(ldiv), .settle_i(settle), .cmp_i(cmp), .sh_strobe_o(strobe),
        .mux_sel_o(sel), .trial_o(trial), .busy_o(busy), .overrun_o(ovr),
        .res_valid_o(valid), .res_chan_o(rchan), .res_word_o(rword), .results_o(results)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [NBITS-1:0] exp_word(input logic [NBITS+FB-1:0] fine);
        logic [NBITS+FB-1:0] m;
        if (fine == '0) return '0;
        m = fine - 1'b1;
        return m[NBITS+FB-1:FB];
    endfunction

    // Monitor: pop and compare each result as it appears.
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected result", rchan, 0);
            end else begin
                mon_item = exp_q.pop_front();
                check(rchan == mon_item[CH_W+NBITS-1:NBITS], "R5 R6 channel order", rchan, mon_item[CH_W+NBITS-1:NBITS]);
                check(rword == mon_item[NBITS-1:0], "R3 result word", rword, mon_item[NBITS-1:0]);
                check(results[rchan*NBITS +: NBITS] == rword, "R8 per-channel register", results[rchan*NBITS +: NBITS], rword);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Push the expected items of the pass, then pulse the peak (R2, R6, R7, R9).
    task automatic start_pass(input bit push, input bit exp_ovr, input bit meas);
        int first_ch = -1;
        int k;
        for (int s = 0; s < NSLOT; s++) begin
            if (s < int'(len) && sdiv[s] != 0 && (pass_no % sdiv[s]) == 0) begin
                if (first_ch < 0) first_ch = sch[s];
                if (push) exp_q.push_back({CH_W'(sch[s]), exp_word(ang[sch[s]])});
            end
        end
        pass_no++;
        peak = 1'b1;
        @(negedge clk);
        peak = 1'b0;
        check(strobe == 1'b1, "R2 strobe after peak", strobe, 1);
        check(busy == 1'b1, "R2 busy after peak", busy, 1);
        check(ovr == exp_ovr, "R9 overrun flag", ovr, exp_ovr);
        @(negedge clk);
        check(strobe == 1'b0, "R2 strobe single cycle", strobe, 0);
        if (meas && first_ch >= 0) begin
            k = 1;
            while (trial != {1'b1, {(NBITS-1){1'b0}}} && k < 100) begin
                @(negedge clk);
                k++;
            end
            check(k == int'(settle) + 2, "R7 settle delay", k, int'(settle) + 2);
            check(int'(sel) == first_ch, "R5 first slot channel", sel, first_ch);
        end
    endtask

    // Wait for the pass to end and confirm nothing is left over (R10).
    task automatic finish_pass();
        int n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        check(busy == 1'b0, "R10 busy falls", busy, 0);
        check(trial == '0, "R10 trial zero when idle", trial, 0);
        check(exp_q.size() == 0, "R6 all scheduled slots done", exp_q.size(), 0);
    endtask

    initial begin
        for (int s = 0; s < NSLOT; s++) begin
            lchan[s*CH_W +: CH_W]   = CH_W'(sch[s]);
            ldiv[s*DIV_W +: DIV_W]  = DIV_W'(sdiv[s]);
        end
        for (int c = 0; c < NCH; c++) ang[c] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !strobe && !ovr && !valid, "R1 reset flags", {busy, strobe, ovr, valid}, 0);
        check(trial == '0 && sel == '0, "R1 reset trial and select", trial, 0);
        check(results == '0, "R1 reset results", results, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Boundary angles: 180 deg exact, just above, zero, full scale (R3).
        ang[0] = 12'h000; ang[1] = 12'hFFF; ang[2] = 12'h800; ang[3] = 12'h801;
        len = 3'd5;
        settle = 4'd4;
        start_pass(1'b1, 1'b0, 1'b1);
        finish_pass();

        // Reach the tenth pass of the divide-by-ten slot with varied angles (R6).
        for (int p = 1; p <= 11; p++) begin
            for (int c = 0; c < NCH; c++) ang[c] = 12'((p * 419 + c * 887 + 5) & 12'hFFF);
            settle = SET_W'(p % 3);
            start_pass(1'b1, 1'b0, (p % 4) == 0);
            finish_pass();
        end

        // Shortened list and an empty list (R5, R10).
        len = 3'd1;
        start_pass(1'b1, 1'b0, 1'b1);
        finish_pass();
        len = 3'd0;
        start_pass(1'b1, 1'b0, 1'b0);
        finish_pass();

        // Peak during a settle: first pass dropped, second runs (R9).
        len = 3'd5;
        settle = 4'd15;
        for (int c = 0; c < NCH; c++) ang[c] = 12'(c * 1000 + 77);
        start_pass(1'b0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        check(busy == 1'b1 && trial == '0, "R7 no trial during settle", trial, 0);
        for (int c = 0; c < NCH; c++) ang[c] = 12'(4000 - c * 900);
        start_pass(1'b1, 1'b1, 1'b0);
        finish_pass();

        // Normal pass after the overrun.
        settle = 4'd2;
        start_pass(1'b1, 1'b0, 1'b1);
        finish_pass();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule